// File: doc/BRIEF.md
# Two-Word Accumulator Processor Core

This block is a small multi-cycle processor with a 16-bit word. Its datapath is built around one accumulator. Every instruction takes two memory words. The core fetches them one at a time. The program counter goes to the address register, the word read back lands in the data register, and from there it moves into the matching half of a 32-bit instruction register.

Once the instruction is assembled, the core decodes three fields: a 12-bit opcode, a register-mode bit and a 3-bit register selector. A fourth field holds a 16-bit memory address, which is always used directly. The register operand comes from one of eight general registers. It is either the value in the register, or the memory word at the address that register holds. Memory operands pass through the data register, an indirect operand is placed in the accumulator first, and every result ends up in the accumulator.

The eight general registers are loaded from a parameter when reset is applied; no instruction writes them. The only outside connections are a single-port synchronous word memory and a halt indication.

Top module: `accum_core`

## Requirements
- R1: While reset is high and after it is released, the program counter, accumulator and flags are zero. The memory address and write enable are zero, and halt is low. Execution starts at word address 0.
- R2: An instruction is two words. The word at the lower address holds bits 31..16 and the next word holds bits 15..0. The opcode is bits 31..20, the mode bit is bit 19, the register selector is bits 18..16 and the memory address is bits 15..0. The program counter steps by one for each word fetched.
- R3: Opcode 1 (ADD) with mode 0 sets the accumulator to mem[reg] + mem[address], wrapping modulo 2^16.
- R4: Opcode 1 (ADD) with mode 1 sets the accumulator to reg + mem[address], wrapping modulo 2^16.
- R5: Opcode 2 (LOAD) sets the accumulator to mem[address] and leaves the flags unchanged.
- R6: Opcode 3 (STORE) writes the accumulator to mem[address]. The write enable is high for exactly one cycle.
- R7: Only ADD updates the flags output. Bit 0 is zero, bit 1 is carry out, bit 2 is the sign of the result and bit 3 is signed overflow.
- R8: Any opcode from 4 to 4095 leaves the accumulator, the flags and memory unchanged.
- R9: Opcode 0 (HALT) raises halt. Halt then stays high with no memory write until the next reset.
- R10: Fetching an instruction takes 7 cycles. Executing it takes 8 more cycles for ADD in mode 0, 5 for ADD in mode 1 or LOAD, 2 for STORE, 1 for an unsupported opcode and 1 for HALT.
- R11: Reset loads general register i from bits 16*i+15..16*i of the parameter GPR_INIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Word address presented to memory |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| mem_we | output | 1 | Memory write enable |
| flags | output | 4 | {overflow, sign, carry, zero} |
| halted | output | 1 | High once HALT has executed |

## Verification
Each result follows from the cycle budget in R10. With the memory's one-cycle read latency, a program of n instructions raises halt after exactly the sum of its per-instruction fetch and execute cycles, counted in rising edges after reset is released. The bench adds up that sum from its own reference interpreter and checks that halt first appears on that edge, no earlier and no later. The bench samples on the falling edge, and it compares the memory image and the flags only after halt. At that point every store has landed and the flags are final. It then waits a few more cycles to confirm that nothing changes after halt.

// File: rtl/accum_core.sv
module accum_core #(
  parameter logic [127:0] GPR_INIT = '0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  output logic        mem_we,
  output logic [3:0]  flags,
  output logic        halted
);
  localparam logic [4:0] S_FHA = 5'd0,  S_FHW = 5'd1,  S_FHD = 5'd2,  S_FHI = 5'd3,
                         S_FLW = 5'd4,  S_FLD = 5'd5,  S_FLI = 5'd6,  S_DEC = 5'd7,
                         S_INW = 5'd8,  S_IND = 5'd9,  S_INA = 5'd10, S_MA  = 5'd11,
                         S_MW  = 5'd12, S_MD  = 5'd13, S_EX  = 5'd14, S_ST  = 5'd15,
                         S_HLT = 5'd16;
  localparam logic [11:0] OP_HALT = 12'd0, OP_ADD = 12'd1, OP_LOAD = 12'd2, OP_STORE = 12'd3;

  logic [4:0]  state;
  logic [15:0] pc, ac, mar, dr;
  logic [31:0] ir;
  logic [15:0] gpr [8];

  wire [11:0] op    = ir[31:20];
  wire        mode  = ir[19];
  wire [2:0]  rsel  = ir[18:16];
  wire [15:0] maddr = ir[15:0];
  wire [16:0] sum   = {1'b0, ac} + {1'b0, dr};
  wire        add_done = (state == S_EX) && (op == OP_ADD);

  assign mem_addr  = mar;
  assign mem_wdata = ac;
  assign mem_we    = (state == S_ST);
  assign halted    = (state == S_HLT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FHA;
      pc    <= '0;
      ac    <= '0;
      mar   <= '0;
      dr    <= '0;
      ir    <= '0;
      flags <= '0;
      for (int i = 0; i < 8; i++) gpr[i] <= GPR_INIT[i*16 +: 16];
    end else begin
      case (state)
        S_FHA: begin mar <= pc; state <= S_FHW; end
        S_FHW: begin pc <= pc + 16'd1; state <= S_FHD; end
        S_FHD: begin dr <= mem_rdata; state <= S_FHI; end
        S_FHI: begin ir[31:16] <= dr; mar <= pc; state <= S_FLW; end
        S_FLW: begin pc <= pc + 16'd1; state <= S_FLD; end
        S_FLD: begin dr <= mem_rdata; state <= S_FLI; end
        S_FLI: begin ir[15:0] <= dr; state <= S_DEC; end
        S_DEC: begin
          case (op)
            OP_HALT: state <= S_HLT;
            OP_ADD:
              if (mode) begin ac <= gpr[rsel]; state <= S_MA; end
              else begin mar <= gpr[rsel]; state <= S_INW; end
            OP_LOAD: state <= S_MA;
            OP_STORE: begin mar <= maddr; state <= S_ST; end
            default: state <= S_FHA;
          endcase
        end
        S_INW: state <= S_IND;
        S_IND: begin dr <= mem_rdata; state <= S_INA; end
        S_INA: begin ac <= dr; state <= S_MA; end
        S_MA:  begin mar <= maddr; state <= S_MW; end
        S_MW:  state <= S_MD;
        S_MD:  begin dr <= mem_rdata; state <= S_EX; end
        S_EX: begin
          if (add_done) begin
            ac    <= sum[15:0];
            flags <= {(ac[15] == dr[15]) && (sum[15] != ac[15]), sum[15], sum[16], sum[15:0] == 16'd0};
          end else begin
            ac <= dr;
          end
          state <= S_FHA;
        end
        S_ST:  state <= S_FHA;
        S_HLT: state <= S_HLT;
        default: state <= S_FHA;
      endcase
    end
  end
endmodule

// File: rtl/accum_core_chk.sv
module accum_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        halted,
  input logic        mem_we,
  input logic [3:0]  flags,
  input logic [15:0] pc,
  input logic        add_done
);
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (flags == 4'd0 && pc == 16'd0 && !halted && !mem_we));
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst) !$stable(pc) |-> pc == $past(pc) + 16'd1);
  assert_single_write_R6: assert property (@(posedge clk) disable iff (rst) mem_we |=> !mem_we);
  assert_flags_add_only_R7: assert property (@(posedge clk) disable iff (rst) !$stable(flags) |-> $past(add_done));
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst) halted |=> halted);
  assert_halt_no_write_R9: assert property (@(posedge clk) disable iff (rst) halted |-> !mem_we);
endmodule

bind accum_core accum_core_chk u_chk (
  .clk(clk), .rst(rst), .halted(halted), .mem_we(mem_we),
  .flags(flags), .pc(pc), .add_done(add_done)
);

// File: tb/sim_accum_core.sv
module sim_accum_core;
  localparam logic [127:0] GI = {16'h0231, 16'h022A, 16'h0223, 16'h021C,
                                 16'h0215, 16'h020E, 16'h0207, 16'h0200};
  localparam int DBASE = 12'h200;
  localparam int DLEN  = 65;

  logic clk = 0, rst = 1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_we, halted;
  logic [3:0] flags;
  logic [15:0] mem [4096];
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  accum_core #(.GPR_INIT(GI)) u0 (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .flags(flags), .halted(halted)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  logic [31:0] prog [16];
  int          plen;
  logic [15:0] dinit [DLEN];
  logic [15:0] emem [DLEN];
  logic [15:0] eac;
  logic [3:0]  efl;
  int          ecyc;

  function automatic logic [15:0] gval(input int i);
    return 16'h0200 + 16'(7 * i);
  endfunction

  // R2: opcode 31..20, mode 19, register 18..16, address 15..0
  function automatic logic [31:0] enc(input int op, input bit md, input int r, input int a);
    return {12'(op), md, 3'(r), 16'(a)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model();
    logic [15:0] a, d;
    logic [16:0] s;
    for (int i = 0; i < DLEN; i++) emem[i] = dinit[i];
    eac = 0; efl = 0; ecyc = 0;
    for (int i = 0; i < plen; i++) begin
      int op = int'(prog[i][31:20]);
      int r  = int'(prog[i][18:16]);
      int ad = int'(prog[i][15:0]) - DBASE;
      ecyc += 7;
      if (op == 0) begin ecyc += 1; break; end
      else if (op == 1) begin
        if (prog[i][19]) begin a = gval(r); ecyc += 5; end
        else begin a = emem[gval(r) - DBASE]; ecyc += 8; end
        d = emem[ad];
        s = {1'b0, a} + {1'b0, d};
        eac = s[15:0];
        efl = {(a[15] == d[15]) && (s[15] != a[15]), s[15], s[16], s[15:0] == 16'd0};
      end
      else if (op == 2) begin eac = emem[ad]; ecyc += 5; end
      else if (op == 3) begin emem[ad] = eac; ecyc += 2; end
      else ecyc += 1;
    end
  endtask

  task automatic run(input string tag);
    int cyc;
    logic [15:0] last;
    model();
    rst = 1;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
    for (int i = 0; i < plen; i++) begin
      mem[2*i]   = prog[i][31:16];
      mem[2*i+1] = prog[i][15:0];
    end
    for (int i = 0; i < DLEN; i++) mem[DBASE + i] = dinit[i];
    repeat (2) @(negedge clk);
    chk(flags == 0 && !halted && !mem_we && mem_addr == 0, "R1 reset state", {flags, halted, mem_we, mem_addr}, 0);
    rst = 0;
    cyc = 0;
    do begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end while (!halted && cyc < 3000);
    chk(cyc < 3000, "R9 halt reached (watchdog)", cyc, ecyc);
    chk(cyc == ecyc, "R2 R10 cycles to halt", cyc, ecyc);
    chk(flags == efl, "R7 flags", flags, efl);
    for (int i = 0; i < DLEN; i++)
      if (mem[DBASE + i] != emem[i]) chk(0, {"R3 R4 R5 R6 R8 memory ", tag}, mem[DBASE + i], emem[i]);
    chk(1, "R6 memory image", 0, 0);
    last = mem[DBASE + 64];
    repeat (4) @(negedge clk);
    chk(halted && mem[DBASE + 64] == last, "R9 halt holds, no write", {halted, mem[DBASE + 64]}, {1'b1, last});
  endtask

  task automatic randdata();
    for (int i = 0; i < DLEN; i++) dinit[i] = 16'($urandom());
  endtask

  initial begin
    void'($urandom(1234));

    // R3 + R7: signed overflow, 0x7FFF + 1
    randdata(); dinit[0] = 16'h7FFF; dinit[1] = 16'h0001;
    prog[0] = enc(1, 0, 0, 16'h201); prog[1] = enc(3, 0, 0, 16'h240); prog[2] = enc(0, 0, 0, 0); plen = 3;
    run("ovf");
    chk(mem[16'h240] == 16'h8000, "R3 indirect add", mem[16'h240], 16'h8000);
    chk(flags == 4'b1100, "R7 overflow+sign", flags, 4'b1100);

    // R7: 0xFFFF + 1 gives zero and carry
    randdata(); dinit[0] = 16'hFFFF; dinit[1] = 16'h0001;
    run("carry");
    chk(flags == 4'b0011, "R7 zero+carry", flags, 4'b0011);

    // R4 + R11: mode 1 uses register value; R8 NOP and R5 LOAD keep flags
    randdata(); dinit[63] = 16'h0000; dinit[2] = 16'h1234;
    prog[0] = enc(1, 1, 5, 16'h23F); prog[1] = enc(3, 0, 0, 16'h240);
    prog[2] = enc(12'hABC, 1, 3, 16'h240); prog[3] = enc(2, 0, 0, 16'h202);
    prog[4] = enc(3, 0, 0, 16'h23E); prog[5] = enc(0, 0, 0, 0); plen = 6;
    run("direct");
    chk(mem[16'h240] == 16'h0223, "R4 R11 direct register operand", mem[16'h240], 16'h0223);
    chk(mem[16'h23E] == 16'h1234, "R5 load", mem[16'h23E], 16'h1234);
    chk(flags == 4'b0000, "R5 R8 flags kept after nop/load", flags, 4'b0000);

    // R9: halt as first instruction
    randdata(); prog[0] = enc(0, 1, 7, 16'h240); plen = 1;
    run("halt");
    chk(ecyc == 8, "R10 halt-only budget", ecyc, 8);

    // random programs
    for (int t = 0; t < 40; t++) begin
      int n = $urandom_range(1, 12);
      randdata();
      for (int i = 0; i < n; i++) begin
        int k = $urandom_range(0, 9);
        int a = DBASE + $urandom_range(0, 63);
        int r = $urandom_range(0, 7);
        bit md = 1'($urandom_range(0, 1));
        if (k <= 3 || k == 9) prog[i] = enc(1, md, r, a);
        else if (k <= 5) prog[i] = enc(2, md, r, a);
        else if (k <= 7) prog[i] = enc(3, md, r, a);
        else prog[i] = enc(4 + $urandom_range(0, 4091), md, r, a);
      end
      prog[n] = enc(3, 0, 0, 16'h240);
      prog[n+1] = enc(0, 0, 0, 0);
      plen = n + 2;
      run("random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule